// File: doc/BRIEF.md
# Picture-in-Picture Window Overlay Generator

This block decides, pixel by pixel, where a reduced sub-picture sits on top of the main picture. It counts clocks from each falling edge of the active-low horizontal sync and counts lines from each falling edge of the active-low vertical sync. It then compares both counts with a programmable window position and with a window size of one third or one quarter of the active area.

Inside the window it raises a switch flag that selects the sub-picture. It also raises a read strobe with window-relative coordinates, which a field store uses to fetch reduced pixels. A one-pixel ring on the outline of the window is flagged as the frame. When the colored-border option is on, the block drives a constant border color on that ring and suppresses the read strobe there.

Any of the four window edges can be cut back by a 6-bit margin, with one margin for the vertical direction and one for the horizontal direction. The cut is either applied at once (display-area mode) or swept inward one step per field (wipe mode). The video data path itself lies outside this block.

Top module: `pip_window_gen`

## Requirements
- R1: Sync inputs are active low. The pixel count restarts at 0 on each falling edge of `hsync_n`. The line count restarts at 0 on each falling edge of `vsync_n` and otherwise advances on each falling edge of `hsync_n`. Both counts saturate at all ones, which is also their reset value, so after reset no output is active until syncs arrive.
- R2: The window covers pixel counts `pos_h` to `pos_h+W-1` and line counts `pos_v` to `pos_v+H-1`. Every output is registered and reflects the counts one clock earlier.
- R3: W is ACTIVE_PIX/3 when `size_h_qtr`=0 and ACTIVE_PIX/4 when it is 1. H is ACTIVE_LINES/3 or ACTIVE_LINES/4 according to `size_v_qtr` in the same way.
- R4: With `disp_en`=0, the outputs `sub_sel`, `frame_flag`, `rd_en` and all frame color outputs stay 0.
- R5: `frame_flag` is high exactly on visible window positions whose relative column is 0 or W-1, or whose relative line is 0 or H-1.
- R6: When `border_en`=1, the frame color outputs carry `border_y`, `border_r` and `border_b` on frame positions and `rd_en` is low there. Otherwise the colors are 0 and `rd_en` also covers frame positions.
- R7: In display-area mode (`cut_en`=1, `cut_wipe`=0), each selected edge hides `cut_v` lines (top, bottom) or `cut_h` pixels (left, right) of the window, counted from that edge.
- R8: In wipe mode (`cut_en`=1, `cut_wipe`=1), the applied margins are 0 while wipe mode is inactive. On each `vsync_n` falling edge they grow by one toward `cut_v` and `cut_h`, and they then hold at those values.
- R9: With `cut_en`=0, the whole window is shown whatever the edge selects and margins are.
- R10: `rd_x` and `rd_y` equal the pixel and line position relative to the window's top-left corner while `rd_en` is high, and they are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Main horizontal sync, active low |
| vsync_n | input | 1 | Main vertical sync, active low |
| disp_en | input | 1 | Sub-picture on |
| pos_v | input | 8 | Window top line |
| pos_h | input | 8 | Window left pixel |
| size_v_qtr | input | 1 | Height 1/4 (1) or 1/3 (0) |
| size_h_qtr | input | 1 | Width 1/4 (1) or 1/3 (0) |
| border_en | input | 1 | Colored border on |
| border_y | input | 4 | Border luma |
| border_r | input | 4 | Border R-Y |
| border_b | input | 4 | Border B-Y |
| cut_en | input | 1 | Edge cutting on |
| cut_wipe | input | 1 | 1: wipe, 0: display area |
| cut_top | input | 1 | Cut top edge |
| cut_bot | input | 1 | Cut bottom edge |
| cut_left | input | 1 | Cut left edge |
| cut_right | input | 1 | Cut right edge |
| cut_v | input | 6 | Vertical margin in lines |
| cut_h | input | 6 | Horizontal margin in pixels |
| sub_sel | output | 1 | Show sub-picture |
| frame_flag | output | 1 | On window outline |
| frame_y | output | 4 | Border luma out |
| frame_r | output | 4 | Border R-Y out |
| frame_b | output | 4 | Border B-Y out |
| rd_en | output | 1 | Sub-picture read strobe |
| rd_x | output | 10 | Window-relative pixel |
| rd_y | output | 10 | Window-relative line |

## Verification
The wipe sweep is the hardest behaviour to reach. It only moves at field boundaries, and its effect is visible only as whole lines vanishing from the window over several consecutive fields. The stimulus therefore generates complete fields of sync pulses. It first leaves cutting off for one field so that the sweep starts from zero, then switches to wipe mode and counts visible pixels field by field until the margin settles. Every clock is also compared against a behavioural model of counters, window and margins.

// File: rtl/pip_pkg.sv
package pip_pkg;
  typedef struct packed {
    logic [3:0] y;
    logic [3:0] r;
    logic [3:0] b;
  } pip_color_t;

  function automatic int unsigned frac_len(int unsigned total, bit quarter);
    return quarter ? total / 4 : total / 3;
  endfunction
endpackage

// File: rtl/pip_edge_counter.sv
module pip_edge_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          step,
  output logic          fall,
  output logic [CW-1:0] cnt
);
  logic          sync_q;
  logic [CW-1:0] cnt_nxt;

  assign fall = sync_q & ~sync_n;

  always_comb begin
    cnt_nxt = cnt;
    if (fall)                         cnt_nxt = '0;
    else if (step && (cnt != '1))     cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      cnt    <= '1;
    end else begin
      sync_q <= sync_n;
      cnt    <= cnt_nxt;
    end
  end

  p_count_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (cnt == '0));
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && step && (cnt != '1)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pip_wipe_step.sv
module pip_wipe_step #(
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          field,
  input  logic [MW-1:0] limit,
  output logic [MW-1:0] cur
);
  logic [MW-1:0] cur_nxt;

  always_comb begin
    cur_nxt = cur;
    if (!active)    cur_nxt = '0;
    else if (field) cur_nxt = (cur < limit) ? cur + 1'b1 : limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= cur_nxt;
  end

  p_wipe_unit_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur > $past(cur)) |-> (cur == $past(cur) + 1'b1));
  p_wipe_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cur == '0));
endmodule

// File: rtl/pip_window_gen.sv
module pip_window_gen #(
  parameter int ACTIVE_PIX   = 96,
  parameter int ACTIVE_LINES = 24,
  parameter int PIX_W        = 10,
  parameter int LINE_W       = 10,
  parameter int POS_W        = 8,
  parameter int MARGIN_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_n,
  input  logic              vsync_n,
  input  logic              disp_en,
  input  logic [POS_W-1:0]  pos_v,
  input  logic [POS_W-1:0]  pos_h,
  input  logic              size_v_qtr,
  input  logic              size_h_qtr,
  input  logic              border_en,
  input  logic [3:0]        border_y,
  input  logic [3:0]        border_r,
  input  logic [3:0]        border_b,
  input  logic              cut_en,
  input  logic              cut_wipe,
  input  logic              cut_top,
  input  logic              cut_bot,
  input  logic              cut_left,
  input  logic              cut_right,
  input  logic [MARGIN_W-1:0] cut_v,
  input  logic [MARGIN_W-1:0] cut_h,
  output logic              sub_sel,
  output logic              frame_flag,
  output logic [3:0]        frame_y,
  output logic [3:0]        frame_r,
  output logic [3:0]        frame_b,
  output logic              rd_en,
  output logic [PIX_W-1:0]  rd_x,
  output logic [LINE_W-1:0] rd_y
);
  import pip_pkg::*;

  localparam int unsigned W_THIRD = frac_len(ACTIVE_PIX, 1'b0);
  localparam int unsigned W_QTR   = frac_len(ACTIVE_PIX, 1'b1);
  localparam int unsigned H_THIRD = frac_len(ACTIVE_LINES, 1'b0);
  localparam int unsigned H_QTR   = frac_len(ACTIVE_LINES, 1'b1);

  logic              h_fall, v_fall;
  logic [PIX_W-1:0]  px;
  logic [LINE_W-1:0] ln;
  logic [MARGIN_W-1:0] wipe_v, wipe_h;

  pip_edge_counter #(.CW(PIX_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .sync_n(hsync_n), .step(1'b1),
    .fall(h_fall), .cnt(px));
  pip_edge_counter #(.CW(LINE_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .sync_n(vsync_n), .step(h_fall),
    .fall(v_fall), .cnt(ln));

  logic wipe_active;
  assign wipe_active = cut_en & cut_wipe;

  pip_wipe_step #(.MW(MARGIN_W)) u_wipe_v (
    .clk(clk), .rst_n(rst_n), .active(wipe_active), .field(v_fall),
    .limit(cut_v), .cur(wipe_v));
  pip_wipe_step #(.MW(MARGIN_W)) u_wipe_h (
    .clk(clk), .rst_n(rst_n), .active(wipe_active), .field(v_fall),
    .limit(cut_h), .cur(wipe_h));

  // window geometry
  logic [PIX_W-1:0]  win_w, x0, rx, mh;
  logic [LINE_W-1:0] win_h, y0, ry, mv;
  logic              in_x, in_y, blank, on_ring, vis;

  always_comb begin
    win_w = size_h_qtr ? PIX_W'(W_QTR) : PIX_W'(W_THIRD);
    win_h = size_v_qtr ? LINE_W'(H_QTR) : LINE_W'(H_THIRD);
    x0    = PIX_W'(pos_h);
    y0    = LINE_W'(pos_v);
    rx    = px - x0;
    ry    = ln - y0;
    mh    = cut_wipe ? PIX_W'(wipe_h) : PIX_W'(cut_h);
    mv    = cut_wipe ? LINE_W'(wipe_v) : LINE_W'(cut_v);
    in_x  = (px >= x0) && ({1'b0, px} < ({1'b0, x0} + {1'b0, win_w}));
    in_y  = (ln >= y0) && ({1'b0, ln} < ({1'b0, y0} + {1'b0, win_h}));
    blank = cut_en & (
              (cut_top   && (ry < mv)) ||
              (cut_bot   && (({1'b0, ry} + {1'b0, mv}) >= {1'b0, win_h})) ||
              (cut_left  && (rx < mh)) ||
              (cut_right && (({1'b0, rx} + {1'b0, mh}) >= {1'b0, win_w})));
    on_ring = (rx == '0) || (rx == win_w - 1'b1) ||
              (ry == '0) || (ry == win_h - 1'b1);
    vis   = disp_en & in_x & in_y & ~blank;
  end

  // output next state
  logic              sel_n, frm_n, rd_n;
  pip_color_t        col_n, col_q;
  logic [PIX_W-1:0]  rdx_n;
  logic [LINE_W-1:0] rdy_n;

  always_comb begin
    sel_n = vis;
    frm_n = vis & on_ring;
    rd_n  = vis & ~(on_ring & border_en);
    col_n = (frm_n & border_en) ? pip_color_t'{y: border_y, r: border_r, b: border_b}
                                : pip_color_t'('0);
    rdx_n = rd_n ? rx : '0;
    rdy_n = rd_n ? ry : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_sel    <= 1'b0;
      frame_flag <= 1'b0;
      rd_en      <= 1'b0;
      col_q      <= '0;
      rd_x       <= '0;
      rd_y       <= '0;
    end else begin
      sub_sel    <= sel_n;
      frame_flag <= frm_n;
      rd_en      <= rd_n;
      col_q      <= col_n;
      rd_x       <= rdx_n;
      rd_y       <= rdy_n;
    end
  end

  assign frame_y = col_q.y;
  assign frame_r = col_q.r;
  assign frame_b = col_q.b;

  p_off_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (!sub_sel && !frame_flag && !rd_en));
  p_color_on_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((frame_y != '0) || (frame_r != '0) || (frame_b != '0)) |-> frame_flag);
  p_read_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> sub_sel);
  p_border_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_flag && $past(border_en)) |-> !rd_en);
endmodule

// File: tb/tb_pip_window_gen.sv
`timescale 1ns/1ps
module tb_pip_window_gen;
  localparam int AP = 96, AL = 24, LINE_CLK = 120, FIELD_LINES = 30, SAT = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n = 1'b1, vsync_n = 1'b1;
  logic disp_en = 1'b0;
  logic [7:0] pos_v = '0, pos_h = '0;
  logic size_v_qtr = 1'b0, size_h_qtr = 1'b0, border_en = 1'b0;
  logic [3:0] border_y = '0, border_r = '0, border_b = '0;
  logic cut_en = 1'b0, cut_wipe = 1'b0, cut_top = 1'b0, cut_bot = 1'b0;
  logic cut_left = 1'b0, cut_right = 1'b0;
  logic [5:0] cut_v = '0, cut_h = '0;
  logic sub_sel, frame_flag, rd_en;
  logic [3:0] frame_y, frame_r, frame_b;
  logic [9:0] rd_x, rd_y;

  always #2 clk = ~clk;

  pip_window_gen dut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .disp_en(disp_en), .pos_v(pos_v), .pos_h(pos_h),
    .size_v_qtr(size_v_qtr), .size_h_qtr(size_h_qtr),
    .border_en(border_en), .border_y(border_y), .border_r(border_r), .border_b(border_b),
    .cut_en(cut_en), .cut_wipe(cut_wipe), .cut_top(cut_top), .cut_bot(cut_bot),
    .cut_left(cut_left), .cut_right(cut_right), .cut_v(cut_v), .cut_h(cut_h),
    .sub_sel(sub_sel), .frame_flag(frame_flag), .frame_y(frame_y),
    .frame_r(frame_r), .frame_b(frame_b), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y));

  int errors = 0, checks = 0, cycles = 0;
  string phase = "R1 reset";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_px, m_ln, m_wv, m_wh;
  bit m_hs, m_vs;
  int e_sel, e_frm, e_rd, e_y, e_r, e_b, e_x, e_yy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_px = SAT; m_ln = SAT; m_wv = 0; m_wh = 0; m_hs = 1; m_vs = 1;
      e_sel = 0; e_frm = 0; e_rd = 0; e_y = 0; e_r = 0; e_b = 0; e_x = 0; e_yy = 0;
    end else begin
      int w, h, rx, ry, mv, mh;
      bit inw, blank, ring, vis, hf, vf;
      w  = size_h_qtr ? AP / 4 : AP / 3;
      h  = size_v_qtr ? AL / 4 : AL / 3;
      rx = m_px - int'(pos_h);
      ry = m_ln - int'(pos_v);
      inw = rx >= 0 && rx < w && ry >= 0 && ry < h;
      mv = cut_wipe ? m_wv : int'(cut_v);
      mh = cut_wipe ? m_wh : int'(cut_h);
      blank = cut_en && ((cut_top && ry < mv) || (cut_bot && ry >= h - mv) ||
                         (cut_left && rx < mh) || (cut_right && rx >= w - mh));
      ring = rx == 0 || rx == w - 1 || ry == 0 || ry == h - 1;
      vis = disp_en && inw && !blank;
      e_sel = vis;
      e_frm = vis && ring;
      e_rd  = vis && !(ring && border_en);
      e_y = (e_frm && border_en) ? int'(border_y) : 0;
      e_r = (e_frm && border_en) ? int'(border_r) : 0;
      e_b = (e_frm && border_en) ? int'(border_b) : 0;
      e_x  = e_rd ? rx : 0;
      e_yy = e_rd ? ry : 0;
      hf = m_hs && !hsync_n;
      vf = m_vs && !vsync_n;
      if (hf) m_px = 0; else if (m_px < SAT) m_px++;
      if (vf) m_ln = 0; else if (hf && m_ln < SAT) m_ln++;
      if (!(cut_en && cut_wipe)) begin m_wv = 0; m_wh = 0; end
      else if (vf) begin
        m_wv = (m_wv < cut_v) ? m_wv + 1 : int'(cut_v);
        m_wh = (m_wh < cut_h) ? m_wh + 1 : int'(cut_h);
      end
      m_hs = hsync_n; m_vs = vsync_n;
    end
  end

  // per-cycle compare against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sub_sel == e_sel, phase, "sub_sel", sub_sel, e_sel);
      chk(frame_flag == e_frm, phase, "frame_flag R5", frame_flag, e_frm);
      chk(rd_en == e_rd, phase, "rd_en", rd_en, e_rd);
      chk(frame_y == e_y && frame_r == e_r && frame_b == e_b, phase, "frame color R6",
          {frame_y, frame_r, frame_b}, (e_y << 8) | (e_r << 4) | e_b);
      chk(rd_x == e_x && rd_y == e_yy, phase, "read coords R10",
          (rd_y << 10) | rd_x, (e_yy << 10) | e_x);
    end
  end

  int n_sel, n_frm, n_rd, n_col, max_x, max_y, first_l, first_c;

  task automatic run_field();
    n_sel = 0; n_frm = 0; n_rd = 0; n_col = 0; max_x = 0; max_y = 0;
    first_l = -1; first_c = -1;
    for (int l = 0; l < FIELD_LINES; l++) begin
      for (int c = 0; c < LINE_CLK; c++) begin
        @(negedge clk);
        if (sub_sel) begin
          n_sel++;
          if (first_l < 0) begin first_l = l; first_c = c; end
        end
        if (frame_flag) n_frm++;
        if (rd_en) begin
          n_rd++;
          if (rd_x > max_x) max_x = rd_x;
          if (rd_y > max_y) max_y = rd_y;
        end
        if (frame_flag && frame_y == border_y && border_en) n_col++;
        hsync_n = (c < 4) ? 1'b0 : 1'b1;
        vsync_n = (l == 0) ? 1'b0 : 1'b1;
      end
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", "cycle limit", cycles, 150000);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    disp_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(sub_sel == 0 && rd_en == 0 && frame_flag == 0, "R1", "idle before sync",
        sub_sel + rd_en + frame_flag, 0);

    phase = "R3 third size"; pos_v = 8'd5; pos_h = 8'd20;
    run_field();   // first field primes the counters
    run_field();
    chk(n_sel == 256, "R3", "window area 1/3", n_sel, 256);
    chk(n_frm == 76, "R5", "frame ring count", n_frm, 76);
    chk(n_rd == 256, "R6", "reads without border", n_rd, 256);
    chk(max_x == 31 && max_y == 7, "R10", "max read coords", max_x * 100 + max_y, 3107);
    chk(first_l == 5 && first_c == 22, "R2", "window origin", first_l * 1000 + first_c, 5022);

    phase = "R3 quarter size"; size_v_qtr = 1; size_h_qtr = 1;
    run_field();
    chk(n_sel == 144, "R3", "window area 1/4", n_sel, 144);
    size_v_qtr = 0; size_h_qtr = 0;

    phase = "R6 border"; border_en = 1; border_y = 4'd9; border_r = 4'd5; border_b = 4'd3;
    run_field();
    chk(n_rd == 180, "R6", "reads with border", n_rd, 180);
    chk(n_col == 76, "R6", "colored ring", n_col, 76);
    border_en = 0;

    phase = "R4 display off"; disp_en = 0;
    run_field();
    chk(n_sel == 0 && n_frm == 0 && n_rd == 0, "R4", "dark when off", n_sel + n_frm + n_rd, 0);
    disp_en = 1;

    phase = "R7 area top-left"; cut_en = 1; cut_top = 1; cut_left = 1; cut_v = 6'd2; cut_h = 6'd5;
    run_field();
    chk(n_sel == 162, "R7", "top/left cut", n_sel, 162);
    phase = "R7 area bottom-right"; cut_top = 0; cut_left = 0; cut_bot = 1; cut_right = 1;
    run_field();
    chk(n_sel == 162, "R7", "bottom/right cut", n_sel, 162);
    phase = "R7 area all"; cut_top = 1; cut_left = 1;
    run_field();
    chk(n_sel == 88, "R7", "four-edge cut", n_sel, 88);

    phase = "R9 cut disabled"; cut_en = 0;
    run_field();
    chk(n_sel == 256, "R9", "full window", n_sel, 256);

    phase = "R8 wipe"; cut_en = 1; cut_wipe = 1; cut_bot = 0; cut_left = 0; cut_right = 0;
    cut_v = 6'd3;
    run_field();
    chk(n_sel == 224, "R8", "wipe field 1", n_sel, 224);
    run_field();
    chk(n_sel == 192, "R8", "wipe field 2", n_sel, 192);
    run_field();
    chk(n_sel == 160, "R8", "wipe field 3", n_sel, 160);
    run_field();
    chk(n_sel == 160, "R8", "wipe settled", n_sel, 160);
    cut_en = 0; cut_wipe = 0; cut_top = 0;

    phase = "R2 moved window"; pos_v = 8'd10; pos_h = 8'd60;
    run_field();
    chk(first_l == 10 && first_c == 62, "R2", "moved origin", first_l * 1000 + first_c, 10062);
    chk(n_sel == 256, "R2", "moved area", n_sel, 256);

    report();
  end
endmodule